// File: doc/BRIEF.md
# Subrate Time-Slot Interchanger

The block switches channels between two serial time-division highways. Each clock cycle carries one bit. An 8 kHz frame strobe marks the first bit of slot 0, and every slot is eight bit cells wide, sent most significant bit first. Every incoming frame is written bit by bit into one bank of a two-bank data memory while the other bank, holding the previous frame, is read out. The read-out is steered by a connection memory with one entry per output slot. An entry holds a valid flag, a source slot index, a bandwidth code and a subrate bit offset. A connection can move a whole byte (64 kbit/s), a 4-bit field (32 kbit/s) or a 2-bit field (16 kbit/s), or it can move two adjacent bytes of the same frame together as one 128 kbit/s channel.

A controlling processor writes connection entries into a shadow copy at any time. The shadow copy becomes the active map at the next frame strobe. Two access channels let the processor read the byte received in a chosen input slot, or force a byte of its own into a chosen output slot. Both are taken over at a frame boundary. A tristate enable marks the bit cells that carry switched or injected data, so several such blocks can share one outgoing highway.

Top module: `subrate_tsi`

## Requirements
- R1: During reset and until the first frame strobe after reset, `sdo` is 1 and `oe` is 0.
- R2: Bit cell p of an output frame appears on `sdo`/`oe` one clock after input bit cell p. It carries data received in the previous frame. Slot s occupies cells 8s to 8s+7, and cell 8s holds bit 7 of the slot byte.
- R3: An entry with bandwidth code 2 sends the whole byte of its source slot, with `oe` high for all eight cells. Any source may feed any output slot, and one source may feed several output slots.
- R4: Bandwidth code 0 selects a 2-bit field and code 1 a 4-bit field. The field starts at cell offset `cm_off` within the slot (offset 0 is the bit-7 cell) and takes the source bits at the same cell positions. Cells outside the field drive 1 with `oe` low.
- R5: Code 3 on an even output slot s sends source byte `src` in slot s and source byte `src`+1 in slot s+1, both from the same input frame. The entry of slot s+1 is then ignored. Code 3 on an odd slot behaves as code 2.
- R6: An output slot whose entry is not valid drives 1 with `oe` low in all its cells.
- R7: A connection write changes only the shadow copy. The output follows it from the frame that begins at the next strobe, and the frame in progress keeps the old map.
- R8: `acc_rd[k]` shows the byte that input slot `acc_slot[k]` received in the previous frame. It uses the slot index captured at the last strobe and stays constant for the whole frame.
- R9: With `acc_inj_en[k]` captured high at a strobe, output slot `acc_slot[k]` sends `acc_inj_byte[k]` for that frame with `oe` high in all eight cells. This overrides the connection map, and channel 0 wins over channel 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one bit cell per cycle |
| rst | input | 1 | Synchronous active-high reset |
| fs | input | 1 | Frame strobe, high in the cycle of cell 0 |
| sdi | input | 1 | Incoming serial highway |
| sdo | output | 1 | Outgoing serial highway |
| oe | output | 1 | Tristate enable for `sdo` |
| cm_we | input | 1 | Shadow connection write strobe |
| cm_slot | input | SW | Output slot whose entry is written |
| cm_valid | input | 1 | Entry valid flag |
| cm_src | input | SW | Source input slot |
| cm_bw | input | 2 | Bandwidth code: 0 two bits, 1 four bits, 2 byte, 3 pair |
| cm_off | input | 3 | Subrate field start cell within the slot |
| acc_slot | input | 2xSW | Slot index of each access channel |
| acc_inj_en | input | 2 | Inject enable per access channel |
| acc_inj_byte | input | 2x8 | Byte to inject per access channel |
| acc_rd | output | 2x8 | Byte read from the chosen input slot |

## Verification
A bank-select flip that is missed or doubled shows at once in the first slot of the next frame. That slot then carries the current frame, or a frame two back, where the previous frame is expected. A wrong active-map or shadow register shows as a wrong byte or `oe` mask in exactly the slot it covers, within the frame after the strobe that loads it. Access-channel state is sampled mid-frame, before and after a strobe, so a capture made on the wrong edge shows as a stale or early byte on `acc_rd` or in the injected slot.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

    typedef enum logic [1:0] {
        BW_16K  = 2'd0,
        BW_32K  = 2'd1,
        BW_64K  = 2'd2,
        BW_128K = 2'd3
    } bw_e;

    localparam int NUM_ACC = 2;

    // number of bit cells a connection of this bandwidth occupies in a slot
    function automatic logic [3:0] field_width(bw_e bw);
        case (bw)
            BW_16K:  return 4'd2;
            BW_32K:  return 4'd4;
            default: return 4'd8;
        endcase
    endfunction

    // true when cell b of a slot belongs to a field starting at off
    function automatic logic cell_in_field(bw_e bw, logic [2:0] off, logic [2:0] b);
        logic [3:0] lo;
        logic [3:0] hi;
        lo = {1'b0, off};
        hi = lo + field_width(bw);
        if (bw == BW_64K || bw == BW_128K)
            return 1'b1;
        return ({1'b0, b} >= lo) && ({1'b0, b} < hi);
    endfunction

endpackage

// File: rtl/tsi_frame_timer.sv
module tsi_frame_timer #(
    parameter int FRAME_BITS = 256,
    localparam int PW = $clog2(FRAME_BITS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fs,
    output logic [PW-1:0] cur_pos,
    output logic          wsel,
    output logic          bank_q,
    output logic          started_q
);

    logic [PW-1:0] cnt_q;

    assign cur_pos = fs ? '0 : cnt_q;
    assign wsel    = fs ? ~bank_q : bank_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            bank_q    <= 1'b0;
            started_q <= 1'b0;
        end else begin
            cnt_q  <= (cur_pos == PW'(FRAME_BITS - 1)) ? '0 : cur_pos + 1'b1;
            bank_q <= wsel;
            if (fs)
                started_q <= 1'b1;
        end
    end

    // banks exchange roles at every strobe
    assert_bank_swap_R2: assert property (@(posedge clk) disable iff (rst)
        fs |=> (bank_q != $past(bank_q)));

    assert_bank_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !fs |=> $stable(bank_q));

endmodule

// File: rtl/tsi_data_mem.sv
module tsi_data_mem #(
    parameter int SLOTS = 32,
    parameter int NRD   = 3,
    localparam int SW   = $clog2(SLOTS)
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic                     wsel,
    input  logic [SW-1:0]            wslot,
    input  logic [2:0]               wcell,
    input  logic                     din,
    input  logic                     rbank,
    input  logic [NRD-1:0][SW-1:0]   rslot,
    output logic [NRD-1:0][7:0]      rbyte
);

    logic [7:0] mem_q [2][SLOTS];

    // cell 0 of a slot is bit 7 of the stored byte
    always_ff @(posedge clk) begin
        if (we)
            mem_q[wsel][wslot][3'd7 - wcell] <= din;
    end

    for (genvar k = 0; k < NRD; k++) begin : g_rd
        assign rbyte[k] = mem_q[rbank][rslot[k]];
    end

endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem #(
    parameter int SLOTS = 32,
    parameter int EW    = 14,
    localparam int SW   = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fs,
    input  logic          we,
    input  logic [SW-1:0] waddr,
    input  logic [EW-1:0] wentry,
    input  logic [SW-1:0] rd_slot,
    output logic [EW-1:0] ent,
    output logic [EW-1:0] prv
);

    logic [SLOTS-1:0][EW-1:0] shadow_q;
    logic [SLOTS-1:0][EW-1:0] act_q;
    logic [SW-1:0]            prv_slot;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            act_q    <= '0;
        end else begin
            if (we)
                shadow_q[waddr] <= wentry;
            if (fs)
                act_q <= shadow_q;
        end
    end

    assign prv_slot = rd_slot - SW'(rd_slot[0]);
    assign ent      = act_q[rd_slot];
    assign prv      = act_q[prv_slot];

    // the active map never moves inside a frame
    assert_map_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        !fs |=> $stable(act_q));

endmodule

// File: rtl/subrate_tsi.sv
module subrate_tsi
    import tsi_pkg::*;
#(
    parameter int SLOTS = 32,
    localparam int SW   = $clog2(SLOTS),
    localparam int FB   = SLOTS * 8,
    localparam int PW   = $clog2(FB)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      fs,
    input  logic                      sdi,
    output logic                      sdo,
    output logic                      oe,
    input  logic                      cm_we,
    input  logic [SW-1:0]             cm_slot,
    input  logic                      cm_valid,
    input  logic [SW-1:0]             cm_src,
    input  logic [1:0]                cm_bw,
    input  logic [2:0]                cm_off,
    input  logic [NUM_ACC-1:0][SW-1:0] acc_slot,
    input  logic [NUM_ACC-1:0]        acc_inj_en,
    input  logic [NUM_ACC-1:0][7:0]   acc_inj_byte,
    output logic [NUM_ACC-1:0][7:0]   acc_rd
);

    typedef struct packed {
        logic          valid;
        logic [SW-1:0] src;
        bw_e           bw;
        logic [2:0]    off;
    } cm_entry_t;

    localparam int EW  = $bits(cm_entry_t);
    localparam int NRD = NUM_ACC + 1;

    logic [PW-1:0] cur_pos;
    logic          wsel;
    logic          bank_q;
    logic          started_q;

    tsi_frame_timer #(.FRAME_BITS(FB)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .fs        (fs),
        .cur_pos   (cur_pos),
        .wsel      (wsel),
        .bank_q    (bank_q),
        .started_q (started_q)
    );

    // output stage runs one cell behind the input
    logic [PW-1:0] st_pos_q;
    logic          st_on_q;
    logic [NUM_ACC-1:0][SW-1:0] acc_slot_q;
    logic [NUM_ACC-1:0]         inj_en_q;
    logic [NUM_ACC-1:0][7:0]    inj_byte_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_pos_q   <= '0;
            st_on_q    <= 1'b0;
            acc_slot_q <= '0;
            inj_en_q   <= '0;
            inj_byte_q <= '0;
        end else begin
            st_pos_q <= cur_pos;
            st_on_q  <= started_q | fs;
            if (fs) begin
                acc_slot_q <= acc_slot;
                inj_en_q   <= acc_inj_en;
                inj_byte_q <= acc_inj_byte;
            end
        end
    end

    logic [SW-1:0] st_slot;
    logic [2:0]    st_cell;
    assign st_slot = st_pos_q[PW-1:3];
    assign st_cell = st_pos_q[2:0];

    cm_entry_t wr_ent, ent, prv;
    logic [EW-1:0] ent_raw, prv_raw;

    assign wr_ent = '{valid: cm_valid, src: cm_src, bw: bw_e'(cm_bw), off: cm_off};

    tsi_conn_mem #(.SLOTS(SLOTS), .EW(EW)) u_cmem (
        .clk     (clk),
        .rst     (rst),
        .fs      (fs),
        .we      (cm_we),
        .waddr   (cm_slot),
        .wentry  (wr_ent),
        .rd_slot (st_slot),
        .ent     (ent_raw),
        .prv     (prv_raw)
    );

    assign ent = cm_entry_t'(ent_raw);
    assign prv = cm_entry_t'(prv_raw);

    logic unused_prv_off;
    assign unused_prv_off = ^prv.off;

    logic          pair_tail;
    logic [SW-1:0] sw_src;
    logic          sw_on;

    assign pair_tail = st_slot[0] && prv.valid && (prv.bw == BW_128K);
    assign sw_src    = pair_tail ? prv.src + 1'b1 : ent.src;
    assign sw_on     = pair_tail || (ent.valid && cell_in_field(ent.bw, ent.off, st_cell));

    logic [NRD-1:0][SW-1:0] rslot;
    logic [NRD-1:0][7:0]    rbyte;

    assign rslot[0] = sw_src;
    for (genvar k = 0; k < NUM_ACC; k++) begin : g_acc
        assign rslot[k+1] = acc_slot_q[k];
        assign acc_rd[k]  = rbyte[k+1];
    end

    tsi_data_mem #(.SLOTS(SLOTS), .NRD(NRD)) u_dmem (
        .clk   (clk),
        .we    (~rst),
        .wsel  (wsel),
        .wslot (cur_pos[PW-1:3]),
        .wcell (cur_pos[2:0]),
        .din   (sdi),
        .rbank (~bank_q),
        .rslot (rslot),
        .rbyte (rbyte)
    );

    logic [NUM_ACC-1:0] inj_hit;
    for (genvar k = 0; k < NUM_ACC; k++) begin : g_hit
        assign inj_hit[k] = inj_en_q[k] && (acc_slot_q[k] == st_slot);
    end

    always_comb begin
        sdo = 1'b1;
        oe  = 1'b0;
        if (st_on_q) begin
            if (inj_hit[0]) begin
                sdo = inj_byte_q[0][3'd7 - st_cell];
                oe  = 1'b1;
            end else if (inj_hit[1]) begin
                sdo = inj_byte_q[1][3'd7 - st_cell];
                oe  = 1'b1;
            end else if (sw_on) begin
                sdo = rbyte[0][3'd7 - st_cell];
                oe  = 1'b1;
            end
        end
    end

    // idle cells carry ones
    assert_idle_ones_R6: assert property (@(posedge clk) disable iff (rst)
        !oe |-> sdo);

    // nothing leaves before the first strobe
    assert_quiet_start_R1: assert property (@(posedge clk) disable iff (rst)
        !st_on_q |-> !oe);

    // an injected slot always drives the highway
    assert_inject_drive_R9: assert property (@(posedge clk) disable iff (rst)
        (st_on_q && (inj_hit != '0)) |-> oe);

    // the second half of a pair always drives
    assert_pair_tail_R5: assert property (@(posedge clk) disable iff (rst)
        (st_on_q && pair_tail) |-> oe);

    // access read-back holds for a whole frame
    assert_acc_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !fs |=> $stable(acc_rd));

endmodule

// File: tb/sim_subrate_tsi.sv
module sim_subrate_tsi;

    localparam int SLOTS = 8;
    localparam int SW    = 3;
    localparam int FB    = SLOTS * 8;
    localparam int NFR   = 7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fs = 1'b0;
    logic sdi = 1'b0;
    logic sdo, oe;
    logic cm_we = 1'b0;
    logic [SW-1:0] cm_slot = '0;
    logic cm_valid = 1'b0;
    logic [SW-1:0] cm_src = '0;
    logic [1:0] cm_bw = '0;
    logic [2:0] cm_off = '0;
    logic [1:0][SW-1:0] acc_slot = '0;
    logic [1:0] acc_inj_en = '0;
    logic [1:0][7:0] acc_inj_byte = '0;
    logic [1:0][7:0] acc_rd;

    always #10 clk = ~clk;

    subrate_tsi #(.SLOTS(SLOTS)) u0 (
        .clk(clk), .rst(rst), .fs(fs), .sdi(sdi), .sdo(sdo), .oe(oe),
        .cm_we(cm_we), .cm_slot(cm_slot), .cm_valid(cm_valid), .cm_src(cm_src),
        .cm_bw(cm_bw), .cm_off(cm_off), .acc_slot(acc_slot),
        .acc_inj_en(acc_inj_en), .acc_inj_byte(acc_inj_byte), .acc_rd(acc_rd)
    );

    int total = 0;
    int bad = 0;
    int cur_f = -1;
    int cur_p = 0;
    logic go = 1'b0;
    logic done = 1'b0;
    logic cap_sdo [NFR][FB];
    logic cap_oe  [NFR][FB];
    logic [7:0] drv_byte;

    // row: slot, valid, src, bw, off, effective source, oe mask
    localparam logic [22:0] TBL [8] = '{
        {3'd0, 1'b1, 3'd6, 2'd2, 3'd0, 3'd6, 8'hFF},
        {3'd1, 1'b1, 3'd2, 2'd0, 3'd4, 3'd2, 8'h0C},
        {3'd2, 1'b1, 3'd4, 2'd3, 3'd0, 3'd4, 8'hFF},
        {3'd3, 1'b1, 3'd0, 2'd0, 3'd0, 3'd5, 8'hFF},
        {3'd4, 1'b1, 3'd3, 2'd1, 3'd2, 3'd3, 8'h3C},
        {3'd5, 1'b0, 3'd0, 2'd0, 3'd0, 3'd0, 8'h00},
        {3'd6, 1'b1, 3'd1, 2'd0, 3'd6, 3'd1, 8'h03},
        {3'd7, 1'b1, 3'd1, 2'd3, 3'd0, 3'd1, 8'hFF}
    };

    function automatic logic [7:0] dbyte(int f, int s);
        return 8'((f * 53 + s * 29 + 17) % 256);
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_slot(string tag, int f, int s, logic [7:0] exp_b, logic [7:0] exp_m);
        logic [7:0] b, m;
        for (int i = 0; i < 8; i++) begin
            b[7-i] = cap_sdo[f][8*s+i];
            m[7-i] = cap_oe[f][8*s+i];
        end
        check($sformatf("%s frame%0d slot%0d data", tag, f, s), b, exp_b);
        check($sformatf("%s frame%0d slot%0d oe", tag, f, s), m, exp_m);
    endtask

    task automatic cm_write(int s, logic v, int src, int bw, int off);
        cm_slot = SW'(s); cm_valid = v; cm_src = SW'(src);
        cm_bw = 2'(bw); cm_off = 3'(off); cm_we = 1'b1;
        @(negedge clk);
        cm_we = 1'b0;
    endtask

    // serial driver and output capture
    initial begin
        wait (go);
        for (int f = 0; f < NFR; f++) begin
            for (int p = 0; p < FB; p++) begin
                @(negedge clk);
                if (f != 0 || p != 0) begin
                    cap_sdo[cur_f][cur_p] = sdo;
                    cap_oe[cur_f][cur_p]  = oe;
                end
                fs = (p == 0);
                drv_byte = dbyte(f, p / 8);
                sdi = drv_byte[3'(7 - (p % 8))];
                cur_f = f;
                cur_p = p;
            end
        end
        @(negedge clk);
        cap_sdo[cur_f][cur_p] = sdo;
        cap_oe[cur_f][cur_p]  = oe;
        fs = 1'b0;
        done = 1'b1;
    end

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [22:0] row;
        repeat (3) @(negedge clk);
        // R1: quiet while in reset
        check("R1 in reset", {7'd0, sdo, oe} , 8'b10);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 before first strobe", {7'd0, sdo, oe}, 8'b10);

        for (int r = 0; r < 8; r++) begin
            row = TBL[r];
            cm_write(int'(row[22:20]), row[19], int'(row[18:16]), int'(row[15:14]), int'(row[13:11]));
        end
        go = 1'b1;

        // R7: change slot 5 in mid frame 2
        wait (cur_f == 2 && cur_p == 30);
        cm_write(5, 1'b1, 0, 2, 0);

        // R9: channel 1 injects into slot 3, channel 0 reads slot 5
        wait (cur_f == 3 && cur_p == 30);
        acc_slot[0] = 3'd5;
        acc_slot[1] = 3'd3;
        acc_inj_en[1] = 1'b1;
        acc_inj_byte[1] = 8'hA5;

        wait (cur_f == 4 && cur_p == 10);
        check("R8 ch0 read frame4", acc_rd[0], dbyte(3, 5));
        check("R8 ch1 read frame4", acc_rd[1], dbyte(3, 3));

        wait (cur_f == 4 && cur_p == 30);
        acc_slot[0] = 3'd3;
        acc_inj_en[0] = 1'b1;
        acc_inj_byte[0] = 8'h3C;

        wait (cur_f == 4 && cur_p == 40);
        check("R8 mid-frame slot change ignored", acc_rd[0], dbyte(3, 5));

        wait (cur_f == 5 && cur_p == 10);
        check("R8 ch0 read frame5", acc_rd[0], dbyte(4, 3));

        wait (done);

        // R2 R3 R4 R5 R6: table walk over frames 1 and 2
        for (int f = 1; f <= 2; f++) begin
            for (int r = 0; r < 8; r++) begin
                logic [7:0] m;
                string tag;
                row = TBL[r];
                m = row[7:0];
                if (m == 8'h00) tag = "R2 R6";
                else if (row[15:14] == 2'd3 || r == 3) tag = "R2 R5";
                else if (row[15:14] < 2'd2) tag = "R2 R4";
                else tag = "R2 R3";
                chk_slot(tag, f, int'(row[22:20]),
                         (dbyte(f - 1, int'(row[10:8])) & m) | ~m, m);
            end
        end

        // R7: new entry active from frame 3
        chk_slot("R7 shadow applied", 3, 5, dbyte(2, 0), 8'hFF);
        // R9: inject not yet taken in frame 3
        chk_slot("R9 inject waits for strobe", 3, 3, dbyte(2, 5), 8'hFF);
        chk_slot("R9 inject ch1", 4, 3, 8'hA5, 8'hFF);
        chk_slot("R9 ch0 wins", 5, 3, 8'h3C, 8'hFF);
        // R5: pair head unaffected by inject next door
        chk_slot("R5 pair head frame4", 4, 2, dbyte(3, 4), 8'hFF);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule